// File: doc/BRIEF.md
# Radix-2 Complex Butterfly Datapath

This block computes one decimation-in-time butterfly stage of a radix-2 Fourier transform. It accepts two complex samples, A and B, and one complex rotation factor W. W stands for exp(-j*2*pi*k/N). The block forms the complex product W*B. It then produces two outputs: the sum A + W*B and the difference A - W*B. Every complex value travels as one packed 32-bit word with a signed 16-bit real half and a signed 16-bit imaginary half.

The operands and a valid flag are captured in a register stage. The product, the fixed-point rescaling and the sum/difference logic sit between that stage and an output register, which also holds the output valid flag. A new operand set can be accepted on every clock. The block never stalls. It has no overflow saturation: results wrap.

Top module: `bfly_core`

## Requirements
- R1: Every complex word carries its real part in bits [31:16] and its imaginary part in bits [15:0], both two's-complement 16-bit values. W uses Q1.14, so the value 1.0 is 16384.
- R2: The product P = W*B is computed as Pre = (Wre*Bre - Wim*Bim) and Pim = (Wre*Bim + Wim*Bre) at full precision. Each component is then arithmetically shifted right by 14, which floors toward minus infinity, and its low 16 bits are kept.
- R3: The sum output equals A + P per component, wrapped modulo 2^16.
- R4: The difference output equals A - P per component, wrapped modulo 2^16.
- R5: Operands presented with in_valid high before clock edge k appear on the outputs, with out_valid high, after edge k+1. In other words, the latency is two clock edges.
- R6: Operands can be presented on every cycle back to back. Each produces its own result on consecutive cycles.
- R7: While rst is high at a clock edge, out_valid, out_sum and out_diff are cleared to zero. An operand set that is pending when reset arrives produces no result.
- R8: When the registered stage holds no valid operands, out_valid goes low, and out_sum and out_diff keep their previous values whatever appears on the operand inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set on in_a, in_b, in_w is valid |
| in_a | input | 32 | Sample A, packed complex |
| in_b | input | 32 | Sample B, packed complex |
| in_w | input | 32 | Rotation factor W, packed complex Q1.14 |
| out_valid | output | 1 | Result words are new this cycle |
| out_sum | output | 32 | A + W*B, packed complex |
| out_diff | output | 32 | A - W*B, packed complex |

## Verification
The butterfly is driven with three rotation factors, and each one isolates a different part of the product.

- With unity, P equals B. This tests the shift and the add/subtract paths without any rounding.
- With -j, the real and imaginary halves of B swap and one sign changes. This shows whether the cross terms or the halves are miswired.
- With exp(-j*pi/4), all four partial products are nonzero and the floor-rounding of the shift matters. This separates an arithmetic shift from a logical shift or from rounding.

Random operands under each factor are checked against an integer model. Extreme values check the 16-bit wrap of both the product and the sum. Back-to-back streams, idle gaps with junk on the inputs, and a reset that lands while a result is in flight check the latency, hold and flush behaviour.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    localparam int unsigned CW   = 16;   // component width
    localparam int unsigned WW   = 2 * CW; // packed complex word width
    localparam int unsigned QFRC = 14;   // fractional bits of the rotation factor

    typedef logic signed [CW-1:0] comp_t;

    typedef struct packed {
        comp_t re;   // bits [WW-1:CW]
        comp_t im;   // bits [CW-1:0]
    } cplx_t;

    typedef struct packed {
        cplx_t a;
        cplx_t b;
        cplx_t w;
    } opnd_t;

    localparam cplx_t CPLX_ZERO = '{re: '0, im: '0};
    localparam cplx_t CPLX_UNIT = '{re: comp_t'(1 << QFRC), im: '0};

    function automatic cplx_t c_add(input cplx_t x, input cplx_t y);
        cplx_t r;
        r.re = x.re + y.re;
        r.im = x.im + y.im;
        return r;
    endfunction

    function automatic cplx_t c_sub(input cplx_t x, input cplx_t y);
        cplx_t r;
        r.re = x.re - y.re;
        r.im = x.im - y.im;
        return r;
    endfunction

endpackage

// File: rtl/bfly_opnd_stage.sv
module bfly_opnd_stage
    import bfly_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld_i,
    input  opnd_t opnd_i,
    output logic  vld_q,
    output opnd_t opnd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            opnd_q <= '0;
        end else begin
            vld_q  <= vld_i;
            opnd_q <= opnd_i;
        end
    end

endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul
    import bfly_pkg::*;
#(
    parameter int unsigned FRAC = QFRC
) (
    input  cplx_t b_i,
    input  cplx_t w_i,
    output cplx_t p_o
);

    localparam int unsigned PW = 2 * CW;   // partial product width
    localparam int unsigned AW = PW + 1;   // accumulator width

    logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [AW-1:0] acc_re, acc_im;
    logic signed [AW-1:0] sh_re, sh_im;

    always_comb begin
        m_rr   = w_i.re * b_i.re;
        m_ii   = w_i.im * b_i.im;
        m_ri   = w_i.re * b_i.im;
        m_ir   = w_i.im * b_i.re;
        acc_re = AW'(m_rr) - AW'(m_ii);
        acc_im = AW'(m_ri) + AW'(m_ir);
        sh_re  = acc_re >>> FRAC;
        sh_im  = acc_im >>> FRAC;
        p_o.re = comp_t'(sh_re);
        p_o.im = comp_t'(sh_im);
    end

    // R2: a unity factor must return B unchanged
    always_comb begin
        if (w_i == CPLX_UNIT && FRAC == QFRC)
            a_r2_unity_twiddle: assert (p_o == b_i);
    end

endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub
    import bfly_pkg::*;
(
    input  cplx_t a_i,
    input  cplx_t p_i,
    output cplx_t sum_o,
    output cplx_t dif_o
);

    always_comb begin
        sum_o = c_add(a_i, p_i);
        dif_o = c_sub(a_i, p_i);
    end

endmodule

// File: rtl/bfly_out_stage.sv
module bfly_out_stage
    import bfly_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  cplx_t sum_i,
    input  cplx_t dif_i,
    output logic  vld_o,
    output cplx_t sum_o,
    output cplx_t dif_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            sum_o <= CPLX_ZERO;
            dif_o <= CPLX_ZERO;
        end else begin
            vld_o <= en_i;
            if (en_i) begin
                sum_o <= sum_i;
                dif_o <= dif_i;
            end
        end
    end

    // R7: reset clears the valid flag
    a_r7_reset_clears: assert property (@(posedge clk) rst |=> (!vld_o && sum_o == CPLX_ZERO));

    // R8: no capture without valid operands
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(sum_o) && $stable(dif_o) && !vld_o));

endmodule

// File: rtl/bfly_core.sv
module bfly_core
    import bfly_pkg::*;
#(
    parameter int unsigned FRAC = QFRC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [WW-1:0] in_a,
    input  logic [WW-1:0] in_b,
    input  logic [WW-1:0] in_w,
    output logic          out_valid,
    output logic [WW-1:0] out_sum,
    output logic [WW-1:0] out_diff
);

    opnd_t opnd_d, opnd_q;
    logic  stg_vld;
    cplx_t prod, sum_c, dif_c, sum_q, dif_q;

    assign opnd_d = '{a: cplx_t'(in_a), b: cplx_t'(in_b), w: cplx_t'(in_w)};

    bfly_opnd_stage u_opnd (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (in_valid),
        .opnd_i (opnd_d),
        .vld_q  (stg_vld),
        .opnd_q (opnd_q)
    );

    bfly_cmul #(.FRAC(FRAC)) u_cmul (
        .b_i (opnd_q.b),
        .w_i (opnd_q.w),
        .p_o (prod)
    );

    bfly_addsub u_addsub (
        .a_i   (opnd_q.a),
        .p_i   (prod),
        .sum_o (sum_c),
        .dif_o (dif_c)
    );

    bfly_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .en_i  (stg_vld),
        .sum_i (sum_c),
        .dif_i (dif_c),
        .vld_o (out_valid),
        .sum_o (sum_q),
        .dif_o (dif_q)
    );

    assign out_sum  = sum_q;
    assign out_diff = dif_q;

    // R5: a captured operand set yields a result one edge later
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        stg_vld |=> out_valid);

    // R3/R4: sum + difference must equal twice A (mod 2^16) per component
    comp_t chk_re, chk_im;
    assign chk_re = sum_q.re + dif_q.re;
    assign chk_im = sum_q.im + dif_q.im;

    a_r3_r4_pair_consistent: assert property (@(posedge clk) disable iff (rst)
        stg_vld |=> (chk_re == comp_t'({$past(opnd_q.a.re[CW-2:0]), 1'b0}) &&
                     chk_im == comp_t'({$past(opnd_q.a.im[CW-2:0]), 1'b0})));

endmodule

// File: tb/bfly_core_bench.sv
module bfly_core_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_a, in_b, in_w;
    logic        out_valid;
    logic [31:0] out_sum, out_diff;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] W_ONE  = {16'sd16384, 16'sd0};
    localparam logic [31:0] W_NEGJ = {16'sd0, -16'sd16384};
    localparam logic [31:0] W_R45  = {16'sd11585, -16'sd11585};

    always #10 clk = ~clk;   // 50 MHz

    bfly_core u_bfly_core (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_w      (in_w),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_diff  (out_diff)
    );

    // R1/R2: integer model of the product component
    function automatic logic [15:0] prod_c(input logic [31:0] b, input logic [31:0] w, input bit imag);
        longint br = longint'($signed(b[31:16]));
        longint bi = longint'($signed(b[15:0]));
        longint wr = longint'($signed(w[31:16]));
        longint wi = longint'($signed(w[15:0]));
        longint acc;
        acc = imag ? (wr * bi + wi * br) : (wr * br - wi * bi);
        acc = acc >>> 14;
        return acc[15:0];
    endfunction

    // R3: sum model
    function automatic logic [31:0] ref_sum(input logic [31:0] a, b, w);
        logic [15:0] pr = prod_c(b, w, 1'b0);
        logic [15:0] pi = prod_c(b, w, 1'b1);
        return {a[31:16] + pr, a[15:0] + pi};
    endfunction

    // R4: difference model
    function automatic logic [31:0] ref_dif(input logic [31:0] a, b, w);
        logic [15:0] pr = prod_c(b, w, 1'b0);
        logic [15:0] pi = prod_c(b, w, 1'b1);
        return {a[31:16] - pr, a[15:0] - pi};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic drive(input bit v, input logic [31:0] a, b, w);
        in_valid = v; in_a = a; in_b = b; in_w = w;
    endtask

    // one operand set, checked two edges later
    task automatic run_one(input string req, input logic [31:0] a, b, w);
        @(negedge clk); drive(1'b1, a, b, w);
        @(negedge clk); drive(1'b0, 32'hDEAD_BEEF, 32'h1234_5678, 32'h0BAD_F00D);
        @(negedge clk);
        check({req, " R5 valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " R3 sum"},  out_sum,  ref_sum(a, b, w));
        check({req, " R4 diff"}, out_diff, ref_dif(a, b, w));
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R7 reset valid", {31'd0, out_valid}, 32'd0);
        check("R7 reset sum",   out_sum,  32'd0);
        check("R7 reset diff",  out_diff, 32'd0);
    endtask

    task automatic t_unity();
        run_one("R2 unity", {16'sd100, -16'sd200}, {16'sd300, 16'sd45}, W_ONE);
        for (int i = 0; i < 8; i++)
            run_one("R2 unity rnd", $urandom, $urandom, W_ONE);
    endtask

    task automatic t_negj();
        run_one("R2 negj", {16'sd10, 16'sd20}, {16'sd3, 16'sd7}, W_NEGJ);
        for (int i = 0; i < 8; i++)
            run_one("R2 negj rnd", $urandom, $urandom, W_NEGJ);
    endtask

    task automatic t_rot45();
        run_one("R2 rot45 floor", 32'd0, {-16'sd1, 16'sd1}, W_R45);
        for (int i = 0; i < 8; i++)
            run_one("R2 rot45 rnd", $urandom, $urandom, W_R45);
    endtask

    task automatic t_wrap();
        // R3/R4: sum overflow wraps
        run_one("R3 wrap", {16'sd32767, -16'sd32768}, {16'sd1, 16'sd1}, W_ONE);
        check("R3 wrap explicit", out_sum, {16'h8000, 16'h8001});
        // R2: extreme product wraps to -32768 in imaginary half
        run_one("R2 extreme", 32'd0, {-16'sd32768, -16'sd32768}, W_NEGJ);
        check("R2 extreme explicit", out_sum, {16'h8000, 16'h8000});
    endtask

    task automatic t_stream();
        logic [31:0] av [6], bv [6], wv [6];
        for (int i = 0; i < 6; i++) begin
            av[i] = $urandom; bv[i] = $urandom;
            wv[i] = (i % 3 == 0) ? W_ONE : ((i % 3 == 1) ? W_NEGJ : W_R45);
        end
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check("R6 stream valid", {31'd0, out_valid}, 32'd1);
                check("R6 stream sum",  out_sum,  ref_sum(av[c-2], bv[c-2], wv[c-2]));
                check("R6 stream diff", out_diff, ref_dif(av[c-2], bv[c-2], wv[c-2]));
            end
            if (c < 6) drive(1'b1, av[c], bv[c], wv[c]);
            else       drive(1'b0, 32'h0, 32'h0, 32'h0);
        end
    endtask

    task automatic t_hold();
        logic [31:0] s0, d0;
        run_one("R8 pre", {16'sd5, 16'sd6}, {16'sd7, 16'sd8}, W_ONE);
        s0 = out_sum; d0 = out_diff;
        for (int i = 0; i < 3; i++) begin
            drive(1'b0, $urandom, $urandom, $urandom);
            @(negedge clk);
            check("R8 hold valid", {31'd0, out_valid}, 32'd0);
            check("R8 hold sum",  out_sum,  s0);
            check("R8 hold diff", out_diff, d0);
        end
    endtask

    task automatic t_mid_reset();
        @(negedge clk); drive(1'b1, {16'sd1, 16'sd2}, {16'sd3, 16'sd4}, W_ONE);
        @(negedge clk); drive(1'b0, 32'h0, 32'h0, 32'h0); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R7 flush valid", {31'd0, out_valid}, 32'd0);
        check("R7 flush sum", out_sum, 32'd0);
        @(negedge clk);
        check("R7 flush after valid", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, 32'h0, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_unity();
        t_negj();
        t_rot45();
        t_wrap();
        t_stream();
        t_hold();
        t_mid_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule